// File: doc/BRIEF.md
# Fan PWM and Tachometer Controller

This block produces a fan drive signal by pulse-width modulation and measures fan speed from a tachometer pin. Every PWM period holds 256 slots. Each slot lasts a programmable number of system clocks, and an 8-bit duty value sets how many slots at the start of each period are active. Duty and divisor are held in shadow copies that reload only when a period ends. This prevents truncated pulses.

The modulated level then passes through an output stage with three controls:
- a gate that suppresses the waveform,
- a polarity inversion,
- an open-collector option that drives the pin only toward low and releases it through the output enable otherwise.

The tachometer input is asynchronous and goes through a two-flop synchroniser. Rising edges on the synchronised signal are counted over a one-second window. The window is built from a 10 µs tick whose length in system clocks is programmable. At the end of each window the count is latched into a 16-bit result and counting restarts.

Top module: `fan_ctrl`

## Requirements
- R1: In every PWM period the pre-output level is active in the slots whose index (0 to 255) is below the latched duty value. A duty of 0 is never active, and a duty of 255 is active in all but the last slot.
- R2: Each slot lasts (divisor + 1) system clocks, so one period lasts 256 × (divisor + 1) clocks.
- R3: With the invert control set, the pin level is the complement of the gated PWM level.
- R4: With the gate control clear, the PWM is forced inactive before inversion, so the pin sits at the inversion level.
- R5: In push-pull mode (open-collector control 0) the pin output equals the level and the output enable is 1. In open-collector mode the output is always 0 and the enable is 1 exactly when the level is low.
- R6: A new duty or divisor takes effect only at the next period boundary. The current period completes unchanged.
- R7: While reset is asserted, the pin output, the output enable and the tach result are all 0.
- R8: A timebase tick occurs every tick-length system clocks, with a tick length of 0 treated as 1. After WINDOW_TICKS ticks, the tach result takes the number of rising tach edges seen in that window.
- R9: The live edge count saturates at 0xFFFF. A window with more edges than that reports 0xFFFF.
- R10: The tach result changes only at a window end and holds its value in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_duty | input | 8 | Active slots per period |
| cfg_div | input | 15 | Slot length minus one, in clocks |
| cfg_invert | input | 1 | Invert pin polarity |
| cfg_gate_en | input | 1 | Let the PWM reach the pin |
| cfg_open_drain | input | 1 | Open-collector drive mode |
| cfg_tick_clks | input | 11 | System clocks per 10 µs tick |
| tach_in | input | 1 | Asynchronous tachometer pin |
| pwm_out | output | 1 | Pin output value |
| pwm_oe | output | 1 | Pin output enable |
| tach_count | output | 16 | Edges counted in the last window |

## Verification
The pin outputs are registered one clock after the slot counter, and the shadow duty and divisor reload one period after a write. The bench therefore waits two of the longest periods after each configuration change, then counts active cycles over exactly one new period. That count does not depend on phase. The boundary test finds the period start from the one-slot low at duty 255, changes the duty just after it, and expects the old waveform to persist for the rest of that period. The tach result is due once per window, and a window sits at an unknown phase after a tick change. The bench lets three windows pass before sampling and uses tach periods that divide the window evenly, so each window holds an exact edge count.

// File: rtl/fan_pkg.sv
package fan_pkg;
  typedef struct packed {
    logic invert;
    logic gate_en;
    logic open_drain;
  } pin_mode_t;
endpackage

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int DUTY_W = 8,
  parameter int DIV_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] cfg_duty,
  input  logic [DIV_W-1:0]  cfg_div,
  output logic              active_o
);
  localparam logic [DUTY_W-1:0] SLOT_LAST = {DUTY_W{1'b1}};

  logic [DIV_W-1:0]  pre_q,  pre_d;
  logic [DUTY_W-1:0] slot_q, slot_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic [DIV_W-1:0]  div_q,  div_d;
  logic              slot_end, period_end;

  always_comb begin
    slot_end   = (pre_q >= div_q);
    period_end = slot_end && (slot_q == SLOT_LAST);
    pre_d      = slot_end ? '0 : pre_q + 1'b1;
    slot_d     = slot_end ? slot_q + 1'b1 : slot_q;
    duty_d     = period_end ? cfg_duty : duty_q;
    div_d      = period_end ? cfg_div  : div_q;
    active_o   = (slot_q < duty_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      slot_q <= '0;
      duty_q <= '0;
      div_q  <= '0;
    end else begin
      pre_q  <= pre_d;
      slot_q <= slot_d;
      duty_q <= duty_d;
      div_q  <= div_d;
    end
  end

  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> slot_q == DUTY_W'($past(slot_q) + 1'b1)); // R2
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(slot_q)); // R2
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> ($stable(duty_q) && $stable(div_q))); // R6
endmodule

// File: rtl/fan_pin_stage.sv
module fan_pin_stage
  import fan_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active_i,
  input  pin_mode_t mode_i,
  output logic      pin_out_o,
  output logic      pin_oe_o
);
  logic level, out_d, oe_d;
  logic out_q, oe_q;

  always_comb begin
    level = (active_i & mode_i.gate_en) ^ mode_i.invert;
    out_d = mode_i.open_drain ? 1'b0   : level;
    oe_d  = mode_i.open_drain ? ~level : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign pin_out_o = out_q;
  assign pin_oe_o  = oe_q;

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i.open_drain |=> !pin_out_o); // R5
  AST_PP_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i.open_drain |=> pin_oe_o); // R5
  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i.gate_en && !mode_i.open_drain) |=> pin_out_o == $past(mode_i.invert)); // R4
endmodule

// File: rtl/fan_tach_meas.sv
module fan_tach_meas #(
  parameter int TICK_W       = 11,
  parameter int CNT_W        = 16,
  parameter int WINDOW_TICKS = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] cfg_tick_clks,
  input  logic              tach_in,
  output logic [CNT_W-1:0]  result_o
);
  localparam int WIN_W = $clog2(WINDOW_TICKS) + 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  logic [1:0]        sync_q;
  logic              prev_q, edge_seen;
  logic [TICK_W-1:0] tick_q, tick_d, tick_lim;
  logic [WIN_W-1:0]  win_q, win_d;
  logic [CNT_W-1:0]  live_q, live_d, live_inc;
  logic [CNT_W-1:0]  res_q, res_d;
  logic              tick, win_end;

  always_comb begin
    edge_seen = sync_q[1] & ~prev_q;
    tick_lim  = (cfg_tick_clks == '0) ? '0 : cfg_tick_clks - 1'b1;
    tick      = (tick_q >= tick_lim);
    tick_d    = tick ? '0 : tick_q + 1'b1;
    win_end   = tick && (win_q == WIN_LAST);
    win_d     = win_q;
    if (tick) win_d = win_end ? '0 : win_q + 1'b1;
    live_inc  = (edge_seen && live_q != CNT_MAX) ? live_q + 1'b1 : live_q;
    live_d    = win_end ? '0 : live_inc;
    res_d     = win_end ? live_inc : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      tick_q <= '0;
      win_q  <= '0;
      live_q <= '0;
      res_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], tach_in};
      prev_q <= sync_q[1];
      tick_q <= tick_d;
      win_q  <= win_d;
      live_q <= live_d;
      res_q  <= res_d;
    end
  end

  assign result_o = res_q;

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(result_o)); // R10
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q == CNT_MAX && !win_end) |=> live_q == CNT_MAX); // R9
  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (live_q == '0 && win_q == '0)); // R8
endmodule

// File: rtl/fan_ctrl.sv
module fan_ctrl
  import fan_pkg::*;
#(
  parameter int DUTY_W       = 8,
  parameter int DIV_W        = 15,
  parameter int TICK_W       = 11,
  parameter int CNT_W        = 16,
  parameter int WINDOW_TICKS = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] cfg_duty,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_invert,
  input  logic              cfg_gate_en,
  input  logic              cfg_open_drain,
  input  logic [TICK_W-1:0] cfg_tick_clks,
  input  logic              tach_in,
  output logic              pwm_out,
  output logic              pwm_oe,
  output logic [CNT_W-1:0]  tach_count
);
  logic      pwm_active;
  pin_mode_t pin_mode;

  assign pin_mode = '{invert: cfg_invert, gate_en: cfg_gate_en, open_drain: cfg_open_drain};

  fan_pwm_gen #(.DUTY_W(DUTY_W), .DIV_W(DIV_W)) u_pwm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_duty (cfg_duty),
    .cfg_div  (cfg_div),
    .active_o (pwm_active)
  );

  fan_pin_stage u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (pwm_active),
    .mode_i    (pin_mode),
    .pin_out_o (pwm_out),
    .pin_oe_o  (pwm_oe)
  );

  fan_tach_meas #(.TICK_W(TICK_W), .CNT_W(CNT_W), .WINDOW_TICKS(WINDOW_TICKS)) u_tach (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_tick_clks (cfg_tick_clks),
    .tach_in       (tach_in),
    .result_o      (tach_count)
  );
endmodule

// File: tb/fan_ctrl_tb.sv
module fan_ctrl_tb;
  localparam int WIN = 70;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_duty;
  logic [14:0] cfg_div;
  logic        cfg_invert, cfg_gate_en, cfg_open_drain;
  logic [10:0] cfg_tick_clks;
  logic        tach_in;
  logic        pwm_out, pwm_oe;
  logic [15:0] tach_count;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  int tach_half = 1;
  int tach_cnt  = 0;

  fan_ctrl #(.WINDOW_TICKS(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_duty(cfg_duty), .cfg_div(cfg_div),
    .cfg_invert(cfg_invert), .cfg_gate_en(cfg_gate_en), .cfg_open_drain(cfg_open_drain),
    .cfg_tick_clks(cfg_tick_clks), .tach_in(tach_in),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .tach_count(tach_count));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // tach generator: toggles every tach_half cycles, idle low when tach_half is 0
  always @(negedge clk) begin
    if (tach_half == 0) begin
      tach_in  <= 1'b0;
      tach_cnt <= 0;
    end else if (tach_cnt >= tach_half - 1) begin
      tach_in  <= ~tach_in;
      tach_cnt <= 0;
    end else begin
      tach_cnt <= tach_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {duty, div, invert, gate, open_drain}
  localparam int NV = 9;
  localparam int VEC [NV][5] = '{
    '{  0, 0, 0, 1, 0},
    '{128, 0, 0, 1, 0},
    '{255, 1, 0, 1, 0},
    '{ 64, 3, 0, 1, 0},
    '{100, 2, 1, 1, 0},
    '{200, 0, 0, 0, 0},
    '{200, 0, 1, 0, 0},
    '{ 50, 1, 0, 1, 1},
    '{ 50, 1, 1, 1, 1}
  };

  initial begin : watchdog
    #1600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int hi, oe, p, act, lvl;
    tach_in        = 1'b0;
    rst_n          = 1'b0;
    cfg_duty       = 8'd0;
    cfg_div        = 15'd0;
    cfg_invert     = 1'b0;
    cfg_gate_en    = 1'b1;
    cfg_open_drain = 1'b0;
    cfg_tick_clks  = 11'd2047;
    wait_cyc(4);
    chk("R7 reset pwm_out", int'(pwm_out), 0);
    chk("R7 reset pwm_oe", int'(pwm_oe), 0);
    chk("R7 reset tach_count", int'(tach_count), 0);
    rst_n = 1'b1;

    // PWM vectors (R1 R2 R3 R4 R5)
    for (int v = 0; v < NV; v++) begin
      cfg_duty       = 8'(VEC[v][0]);
      cfg_div        = 15'(VEC[v][1]);
      cfg_invert     = VEC[v][2][0];
      cfg_gate_en    = VEC[v][3][0];
      cfg_open_drain = VEC[v][4][0];
      wait_cyc(2 * 256 * 4 + 8);
      p   = 256 * (VEC[v][1] + 1);
      act = VEC[v][3] != 0 ? VEC[v][0] * (VEC[v][1] + 1) : 0;
      lvl = VEC[v][2] != 0 ? p - act : act;
      hi = 0;
      oe = 0;
      repeat (p) begin
        @(negedge clk);
        hi += int'(pwm_out);
        oe += int'(pwm_oe);
      end
      chk($sformatf("R1/R2/R3/R4 vec%0d out-high cycles", v), hi, VEC[v][4] != 0 ? 0 : lvl);
      chk($sformatf("R5 vec%0d oe cycles", v), oe, VEC[v][4] != 0 ? p - lvl : p);
    end

    // R6: change duty just after a period start; old waveform persists
    cfg_duty = 8'd255; cfg_div = 15'd0; cfg_invert = 1'b0;
    cfg_gate_en = 1'b1; cfg_open_drain = 1'b0;
    wait_cyc(2100);
    while (pwm_out != 1'b0) @(negedge clk);
    while (pwm_out != 1'b1) @(negedge clk);
    cfg_duty = 8'd0;
    hi = 0;
    repeat (200) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
    chk("R6 old duty finishes its period", hi, 200);
    wait_cyc(100);
    hi = 0;
    repeat (256) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
    chk("R6 new duty after boundary", hi, 0);

    // R10: no window has ended yet, result still zero
    chk("R10 result held before first window end", int'(tach_count), 0);

    // R9: tach toggling every cycle for a 2047x70 clock window
    while (cyc < 2047 * WIN + 60) @(negedge clk);
    chk("R9 saturated window count", int'(tach_count), 16'hFFFF);

    // R8: short windows of 10 x 70 = 700 clocks
    cfg_tick_clks = 11'd10;
    tach_half = 10;
    wait_cyc(3 * 700 + 20);
    chk("R8 period 20 gives 35 edges", int'(tach_count), 35);
    tach_half = 35;
    wait_cyc(3 * 700 + 20);
    chk("R8 period 70 gives 10 edges", int'(tach_count), 10);
    wait_cyc(300);
    chk("R10 result stable mid-stream", int'(tach_count), 10);
    tach_half = 0;
    wait_cyc(3 * 700 + 20);
    chk("R8 idle tach gives 0", int'(tach_count), 0);
    cfg_tick_clks = 11'd0;
    tach_half = 7;
    wait_cyc(3 * 70 + 20);
    chk("R8 tick length 0 acts as 1 (window 70)", int'(tach_count), 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule